// File: doc/BRIEF.md
# Instruction Namespace Selector Register

This block holds the hidden opcode-extension bits that the instruction decoder appends to every fetched instruction. Software selects a namespace by writing one 32-bit control register through a CSR-style port, and the decoder reads the stored bits every cycle with no stall. The register uses a write-legal, read-legal discipline. Every write is checked in the same cycle against parameters that list the supported encodings. A supported value is stored. An unsupported value is never stored and is never clamped to a nearby value. Instead it raises a one-cycle trap, which lets software detect that it must fall back to emulation.

Bit 0 picks how the other bits are read. When bit 0 is 0 (native mode), bits 4:1 hold a binary 16-bit-opcode page number. Bits 15 to 23 are reserved. Bits 5 to 14 and 24 to 31 are independent feature flags, and bits 24 to 31 are the custom region. When bit 0 is 1 (foreign mode), bits 7:1 hold a binary index of a foreign instruction set, so only one foreign set can be active at a time. Bits 31:8 must be zero in foreign mode.

A small access state machine tracks each write. It has three states. ST_IDLE means no write was seen in the previous cycle. ST_COMMIT means a supported write was stored. ST_TRAP means an unsupported write was refused, and the trap output is high only in this state. From any state, a supported write to the register address moves the machine to ST_COMMIT, an unsupported write moves it to ST_TRAP, and a cycle with no write to the address moves it to ST_IDLE.

Top module: `nsctl_reg`

## Requirements
- R1: After reset the stored value is 0 (native mode, page 0, no flags), the trap output is low, and the read data is 0.
- R2: A supported write with `csr_we` high and `csr_addr` equal to the register address is stored at that clock edge, and it appears on `ns_bits_o` and `ns_foreign_o` (= bit 0) in the following cycle.
- R3: A read with `csr_rd` high and a matching address returns the stored value on `csr_rdata` one cycle later. A read cycle without a matching address returns 0 one cycle later.
- R4: In native mode, a write that sets any bit from 15 to 23 is refused: it traps and leaves the stored value unchanged.
- R5: In native mode, a write whose page field (bits 4:1, read as a binary number) names a page whose bit is clear in the PAGE_OK parameter is refused. The default supports pages 0, 1, 2, 8 and 9.
- R6: In native mode, a write that sets a flag bit (5 to 14 or 24 to 31) which is clear in the FLAG_OK parameter is refused. The default supports bit 6 and bits 24 to 27.
- R7: In foreign mode, a write with any bit in 31:8 set is refused.
- R8: In foreign mode, a write whose index (bits 7:1) has a clear bit in the FOREIGN_OK parameter is refused. The default supports indices 0x10, 0x11 and 0x40.
- R9: Each refused write drives `trap_o` high for exactly the one cycle after its clock edge, and `trap_o` is low after every accepted write.
- R10: A write whose address does not match changes nothing and raises no trap.
- R11: Writes on consecutive cycles are each handled in their own cycle with no stall. A refused write placed between two accepted writes does not disturb either of them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_addr | input | 12 | Access address, compared with the ADDR parameter |
| csr_rd | input | 1 | Read request |
| csr_we | input | 1 | Write request |
| csr_wdata | input | 32 | Write value |
| csr_rdata | output | 32 | Read value, registered, one cycle after the request |
| trap_o | output | 1 | One-cycle pulse after a refused write |
| ns_bits_o | output | 32 | Stored namespace bits, sent to the decoder |
| ns_foreign_o | output | 1 | High when foreign mode is stored |

## Verification
On every cycle, the assertions check four things. The stored value always has the shape of a legal encoding for its mode. A refused write leaves the register stable and is followed by a trap. An accepted write appears unaltered one cycle later. Read data follows the register with exactly one cycle of latency. The directed scenarios are needed for the rest: showing that particular encodings are actually sorted into supported and unsupported according to the default parameter sets, that a mismatched address has no effect, and that interleaved accepted and refused writes resolve in the right order.

// File: rtl/nsctl_pkg.sv
package nsctl_pkg;

    localparam int unsigned NS_W      = 32;
    localparam int unsigned PAGE_LSB  = 1;
    localparam int unsigned PAGE_W    = 4;
    localparam int unsigned FIDX_LSB  = 1;
    localparam int unsigned FIDX_W    = 7;
    localparam int unsigned RSV_LO    = 15;
    localparam int unsigned RSV_HI    = 23;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_COMMIT = 2'd1,
        ST_TRAP   = 2'd2
    } acc_state_e;

    typedef enum logic {
        MODE_NATIVE  = 1'b0,
        MODE_FOREIGN = 1'b1
    } ns_mode_e;

    // contiguous bit span [hi:lo] within an NS_W word
    function automatic logic [NS_W-1:0] bit_span(input int unsigned lo, input int unsigned hi);
        logic [NS_W-1:0] m;
        m = '0;
        for (int unsigned i = 0; i < NS_W; i++) begin
            if (i >= lo && i <= hi) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/nsctl_legal_check.sv
module nsctl_legal_check
    import nsctl_pkg::*;
#(
    parameter logic [(1<<PAGE_W)-1:0] PAGE_OK    = 16'h0307,
    parameter logic [NS_W-1:0]        FLAG_OK    = 32'h0F00_0040,
    parameter logic [(1<<FIDX_W)-1:0] FOREIGN_OK = 128'h0000_0000_0000_0001_0000_0000_0003_0000
) (
    input  logic [NS_W-1:0] value_i,
    output logic            legal_o
);

    localparam logic [NS_W-1:0] MODE_MASK = bit_span(0, 0);
    localparam logic [NS_W-1:0] PAGE_MASK = bit_span(PAGE_LSB, PAGE_LSB + PAGE_W - 1);
    localparam logic [NS_W-1:0] RSV_MASK  = bit_span(RSV_LO, RSV_HI);
    localparam logic [NS_W-1:0] FLAG_MASK = ~(MODE_MASK | PAGE_MASK | RSV_MASK);
    localparam logic [NS_W-1:0] FIDX_MASK = bit_span(FIDX_LSB, FIDX_LSB + FIDX_W - 1);
    localparam logic [NS_W-1:0] FHI_MASK  = ~(MODE_MASK | FIDX_MASK);

    ns_mode_e              mode;
    logic [PAGE_W-1:0]     page;
    logic [FIDX_W-1:0]     fidx;
    logic                  native_ok;
    logic                  foreign_ok;

    always_comb begin
        mode = ns_mode_e'(value_i[0]);
        page = value_i[PAGE_LSB +: PAGE_W];
        fidx = value_i[FIDX_LSB +: FIDX_W];

        native_ok  = ~|(value_i & RSV_MASK)
                   & PAGE_OK[page]
                   & ~|(value_i & FLAG_MASK & ~FLAG_OK);

        foreign_ok = ~|(value_i & FHI_MASK)
                   & FOREIGN_OK[fidx];

        unique case (mode)
            MODE_NATIVE:  legal_o = native_ok;
            MODE_FOREIGN: legal_o = foreign_ok;
            default:      legal_o = 1'b0;
        endcase
    end

    // reset value (all zero) must itself be a supported encoding
    initial begin
        assert_reset_legal_R1: assert (PAGE_OK[0]);
    end

endmodule

// File: rtl/nsctl_access_fsm.sv
module nsctl_access_fsm
    import nsctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_hit_i,
    input  logic wr_legal_i,
    output logic commit_o,
    output logic trap_o
);

    acc_state_e state_q;
    acc_state_e state_d;

    always_comb begin
        unique case ({wr_hit_i, wr_legal_i})
            2'b11:   state_d = ST_COMMIT;
            2'b10:   state_d = ST_TRAP;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        commit_o = wr_hit_i & wr_legal_i;
        unique case (state_q)
            ST_IDLE:   trap_o = 1'b0;
            ST_COMMIT: trap_o = 1'b0;
            ST_TRAP:   trap_o = 1'b1;
            default:   trap_o = 1'b0;
        endcase
    end

    assert_trap_after_refusal_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit_i && !wr_legal_i) |=> trap_o);

    assert_no_trap_after_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit_i && wr_legal_i) |=> !trap_o);

    assert_no_trap_without_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit_i |=> !trap_o);

endmodule

// File: rtl/nsctl_read_port.sv
module nsctl_read_port
    import nsctl_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rd_hit_i,
    input  logic [NS_W-1:0] value_i,
    output logic [NS_W-1:0] rdata_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        rdata_o <= '0;
        else if (rd_hit_i) rdata_o <= value_i;
        else               rdata_o <= '0;
    end

    assert_read_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_hit_i) |-> (rdata_o == $past(value_i)));

    assert_read_miss_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rd_hit_i) |-> (rdata_o == '0));

endmodule

// File: rtl/nsctl_reg.sv
module nsctl_reg
    import nsctl_pkg::*;
#(
    parameter logic [11:0]            ADDR       = 12'h5C0,
    parameter logic [(1<<PAGE_W)-1:0] PAGE_OK    = 16'h0307,
    parameter logic [NS_W-1:0]        FLAG_OK    = 32'h0F00_0040,
    parameter logic [(1<<FIDX_W)-1:0] FOREIGN_OK = 128'h0000_0000_0000_0001_0000_0000_0003_0000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [11:0]      csr_addr,
    input  logic             csr_rd,
    input  logic             csr_we,
    input  logic [NS_W-1:0]  csr_wdata,
    output logic [NS_W-1:0]  csr_rdata,
    output logic             trap_o,
    output logic [NS_W-1:0]  ns_bits_o,
    output logic             ns_foreign_o
);

    logic            addr_hit;
    logic            wr_hit;
    logic            rd_hit;
    logic            wr_legal;
    logic            commit;
    logic [NS_W-1:0] ns_q;

    assign addr_hit = (csr_addr == ADDR);
    assign wr_hit   = csr_we & addr_hit;
    assign rd_hit   = csr_rd & addr_hit;

    nsctl_legal_check #(
        .PAGE_OK    (PAGE_OK),
        .FLAG_OK    (FLAG_OK),
        .FOREIGN_OK (FOREIGN_OK)
    ) u_check (
        .value_i (csr_wdata),
        .legal_o (wr_legal)
    );

    nsctl_access_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_hit_i   (wr_hit),
        .wr_legal_i (wr_legal),
        .commit_o   (commit),
        .trap_o     (trap_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ns_q <= '0;
        else if (commit) ns_q <= csr_wdata;
    end

    nsctl_read_port u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_hit_i(rd_hit),
        .value_i (ns_q),
        .rdata_o (csr_rdata)
    );

    assign ns_bits_o    = ns_q;
    assign ns_foreign_o = ns_q[0];

    assert_native_reserved_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !ns_q[0] |-> (ns_q[RSV_HI:RSV_LO] == '0));

    assert_foreign_upper_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ns_q[0] |-> (ns_q[NS_W-1:8] == '0));

    assert_refused_keeps_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && !wr_legal) |=> $stable(ns_q));

    assert_accepted_stored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && wr_legal) |=> (ns_bits_o == $past(csr_wdata)));

    assert_miss_keeps_value_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> $stable(ns_q));

endmodule

// File: tb/nsctl_reg_bench.sv
module nsctl_reg_bench;

    localparam time CLK_PERIOD = 10ns;
    localparam logic [11:0] A_OK  = 12'h5C0;
    localparam logic [11:0] A_BAD = 12'h5C1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] csr_addr = '0;
    logic        csr_rd = 1'b0;
    logic        csr_we = 1'b0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic        trap_o;
    logic [31:0] ns_bits_o;
    logic        ns_foreign_o;

    int n_run = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nsctl_reg u_nsctl_reg (
        .clk          (clk),
        .rst_n        (rst_n),
        .csr_addr     (csr_addr),
        .csr_rd       (csr_rd),
        .csr_we       (csr_we),
        .csr_wdata    (csr_wdata),
        .csr_rdata    (csr_rdata),
        .trap_o       (trap_o),
        .ns_bits_o    (ns_bits_o),
        .ns_foreign_o (ns_foreign_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // one write, sampled one edge later: trap and stored value
    task automatic wr(input logic [11:0] a, input logic [31:0] d,
                      input logic exp_trap, input logic [31:0] exp_val, input string tag);
        @(negedge clk);
        csr_addr = a; csr_we = 1'b1; csr_wdata = d;
        @(negedge clk);
        csr_we = 1'b0;
        check({tag, " trap"}, {31'd0, trap_o}, {31'd0, exp_trap});
        check({tag, " value"}, ns_bits_o, exp_val);
        @(negedge clk);
        check({tag, " trap drop"}, {31'd0, trap_o}, 32'd0);
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        csr_addr = a; csr_rd = 1'b1;
        @(negedge clk);
        csr_rd = 1'b0;
        check(tag, csr_rdata, exp);
    endtask

    task automatic t_reset;
        check("R1 value", ns_bits_o, 32'h0);
        check("R1 trap", {31'd0, trap_o}, 32'd0);
        check("R1 rdata", csr_rdata, 32'h0);
        rd(A_OK, 32'h0, "R1 read");
    endtask

    task automatic t_native_legal;
        wr(A_OK, 32'h0000_0042, 1'b0, 32'h0000_0042, "R2 page1+flag6");
        check("R2 foreign flag", {31'd0, ns_foreign_o}, 32'd0);
        wr(A_OK, 32'h0100_0012, 1'b0, 32'h0100_0012, "R2 page9+custom24");
    endtask

    task automatic t_read;
        rd(A_OK, 32'h0100_0012, "R3 read hit");
        rd(A_BAD, 32'h0, "R3 read miss");
    endtask

    task automatic t_reserved;
        wr(A_OK, 32'h0000_8000, 1'b1, 32'h0100_0012, "R4 bit15");
        wr(A_OK, 32'h0080_0002, 1'b1, 32'h0100_0012, "R4 bit23");
    endtask

    task automatic t_page;
        wr(A_OK, 32'h0000_0006, 1'b1, 32'h0100_0012, "R5 page3");
        wr(A_OK, 32'h0000_0010, 1'b0, 32'h0000_0010, "R5 page8");
    endtask

    task automatic t_flags;
        wr(A_OK, 32'h1000_0000, 1'b1, 32'h0000_0010, "R6 bit28");
        wr(A_OK, 32'h0000_0020, 1'b1, 32'h0000_0010, "R6 bit5");
    endtask

    task automatic t_foreign;
        wr(A_OK, 32'h0000_0021, 1'b0, 32'h0000_0021, "R8 idx10");
        check("R8 foreign flag", {31'd0, ns_foreign_o}, 32'd1);
        wr(A_OK, 32'h0000_0081, 1'b0, 32'h0000_0081, "R8 idx40");
        wr(A_OK, 32'h0000_0025, 1'b1, 32'h0000_0081, "R8 idx12");
        wr(A_OK, 32'h0000_0123, 1'b1, 32'h0000_0081, "R7 bit8");
        wr(A_OK, 32'h0100_0023, 1'b1, 32'h0000_0081, "R7 bit24");
    endtask

    task automatic t_miss;
        wr(A_BAD, 32'h0000_0002, 1'b0, 32'h0000_0081, "R10 legal miss");
        wr(A_BAD, 32'h0000_8000, 1'b0, 32'h0000_0081, "R10 illegal miss");
    endtask

    task automatic t_back_to_back;
        @(negedge clk);
        csr_addr = A_OK; csr_we = 1'b1; csr_wdata = 32'h0000_0002;
        @(negedge clk);
        check("R11 first", ns_bits_o, 32'h0000_0002);
        check("R11 first trap", {31'd0, trap_o}, 32'd0);
        csr_wdata = 32'h0000_0006;
        @(negedge clk);
        check("R11 refused mid", ns_bits_o, 32'h0000_0002);
        check("R9 mid trap", {31'd0, trap_o}, 32'd1);
        csr_wdata = 32'h0000_0023;
        @(negedge clk);
        csr_we = 1'b0;
        check("R11 last", ns_bits_o, 32'h0000_0023);
        check("R9 trap one cycle", {31'd0, trap_o}, 32'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_native_legal;
        t_read;
        t_reserved;
        t_page;
        t_flags;
        t_foreign;
        t_miss;
        t_back_to_back;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule